// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single bus requests from a flash controller into the asynchronous strobe sequence that a raw NAND device expects. A request carries a kind (command, address, data write or data read), a byte and a flag marking it as the start of a long device operation. The block drives the chip enable, the command and address latch enables, the write and read strobes and the data bus (as a separate output, output enable and input), and returns a one-clock completion pulse with the captured byte on reads.

Every phase length is a clock count taken from one 32-bit timing word that the controller holds steady while a cycle runs. A zero count is stretched to one clock. Chip enable stays low across back-to-back requests and is dropped after a short idle period. When a cycle starts a long device operation, the ready/busy pin is ignored for a programmed number of clocks, and the ready flag rises only after that.

Top module: `nand_cycle_gen`

## Requirements
- R1: While reset is held, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale, nand_dq_oe, req_done and rb_valid are low.
- R2: A write-type cycle (req_kind 0 command, 1 address, 2 data write) holds nand_we_n low for timing_word[3:0] clocks, then high for timing_word[7:4] clocks. req_done is high in the last high clock. A count of zero lasts one clock.
- R3: While nand_we_n is low, nand_cle is high only for kind 0 and nand_ale only for kind 1. nand_dq_oe is high and nand_dq_out equals the request byte. nand_cle and nand_ale are never high together.
- R4: A read cycle (req_kind 3) holds nand_re_n low for timing_word[11:8] clocks and high for timing_word[15:12] clocks, with zero read as one. rd_byte holds the value nand_dq_in had in the last low clock, valid while req_done is high.
- R5: A read that follows a write-type cycle while nand_ce_n stayed low first spends timing_word[18:16] clocks (zero read as one) with both strobes high and nand_dq_oe low. nand_dq_oe is never high while nand_re_n is low.
- R6: For a read whose acceptance lowers nand_ce_n, the read-low phase lasts at least timing_word[25:24] clocks, counted from the edge that lowered nand_ce_n.
- R7: req_done is a single-clock pulse. A request is taken only while no cycle is running, and at most one clock after it is presented to an idle block.
- R8: nand_ce_n stays low between back-to-back requests. It rises at the CE_HOLD-th clock edge after the edge that ends a cycle, provided no request arrives in between.
- R9: When a cycle with req_busy set completes, rb_valid is low from the next clock. It stays low for timing_word[23:19] further clocks whatever nand_rb does.
- R10: After that delay, rb_valid rises on the first clock edge at which nand_rb is high, and stays low while nand_rb is low.
- R11: A command cycle with byte 0xFF behaves as a busy-starting cycle even with req_busy low. Other cycles with req_busy low leave rb_valid unchanged.
- R12: nand_we_n and nand_re_n are never low together, and neither is low while nand_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | 32 | Packed phase counts in system clocks |
| req_valid | input | 1 | Request present, held until req_done |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | DQ_W | Byte to send on write-type cycles |
| req_busy | input | 1 | This cycle starts a long device operation |
| req_done | output | 1 | One-clock completion pulse |
| rd_byte | output | DQ_W | Byte captured by the last read cycle |
| rb_valid | output | 1 | Device reported ready after the busy delay |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | DQ_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | DQ_W | Data bus input value |
| nand_rb | input | 1 | Ready/busy from the device, high when ready |

## Verification
The chip-enable access delay is the hardest case to reach. It only shapes a read whose own acceptance drops nand_ce_n, and with ordinary counts it hides behind the read-low time. The stimulus first waits out the idle timeout so that nand_ce_n is high again. It then issues a read with the shortest read-low count and the largest access delay, so the stretched low phase is visible in the counted strobe clocks. The busy delay is also tested with nand_rb held low past the delay, to separate the delay from the pin itself.

// File: rtl/nand_tg_pkg.sv
package nand_tg_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WDAT = 2'd2,
    K_RDAT = 2'd3
  } nand_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } nand_state_e;

  // field positions are fixed: software packs the word this way
  typedef struct packed {
    logic [5:0] spare;
    logic [1:0] ce_acc;
    logic [4:0] busy_dly;
    logic [2:0] turn;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } nand_timing_t;

  localparam int PH_W   = 4;
  localparam int BUSY_W = 5;

  // a zero count still gives one clock
  function automatic logic [PH_W-1:0] phase_len(input logic [PH_W-1:0] n);
    return (n == '0) ? PH_W'(1) : n;
  endfunction

  // counter load value: the entry clock is the first of the phase
  function automatic logic [PH_W-1:0] phase_load(input logic [PH_W-1:0] n);
    return phase_len(n) - PH_W'(1);
  endfunction

endpackage

// File: rtl/nand_tg_seq.sv
module nand_tg_seq
  import nand_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic              do_turn,
  input  logic              ce_ok,
  input  logic [PH_W-1:0]   wr_lo,
  input  logic [PH_W-1:0]   wr_hi,
  input  logic [PH_W-1:0]   rd_lo,
  input  logic [PH_W-1:0]   rd_hi,
  input  logic [2:0]        turn,
  output nand_state_e       st,
  output logic              last_clk,
  output logic              cap_clk
);

  logic [PH_W-1:0] cnt;
  logic            cnt_zero;
  logic [PH_W-1:0] low_ld, high_ld, turn_ld;

  always_comb begin
    low_ld   = is_read ? phase_load(rd_lo) : phase_load(wr_lo);
    high_ld  = is_read ? phase_load(rd_hi) : phase_load(wr_hi);
    turn_ld  = phase_load({1'b0, turn});
    cnt_zero = (cnt == '0);
    cap_clk  = (st == ST_LOW) && cnt_zero && (!is_read || ce_ok);
    last_clk = (st == ST_HIGH) && cnt_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          if (do_turn) begin
            st  <= ST_TURN;
            cnt <= turn_ld;
          end else begin
            st  <= ST_LOW;
            cnt <= low_ld;
          end
        end
        ST_TURN: if (cnt_zero) begin
          st  <= ST_LOW;
          cnt <= low_ld;
        end else cnt <= cnt - PH_W'(1);
        ST_LOW: if (cap_clk) begin
          st  <= ST_HIGH;
          cnt <= high_ld;
        end else if (!cnt_zero) cnt <= cnt - PH_W'(1);
        ST_HIGH: if (cnt_zero) st <= ST_IDLE;
                 else cnt <= cnt - PH_W'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_TURN_LEADS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TURN) |=> (st == ST_TURN || st == ST_LOW)); // R5
  AST_HIGH_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_HIGH) |-> $past(st == ST_LOW)); // R2

endmodule

// File: rtl/nand_tg_ce.sv
module nand_tg_ce #(
  parameter int HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       idle,
  input  logic       req_pending,
  input  logic [1:0] ce_acc,
  output logic       ce_n,
  output logic       ce_ok,
  output logic       ce_rel
);

  localparam int          IW      = $clog2(HOLD + 1);
  localparam logic [2:0]  AGE_MAX = 3'd4;

  logic [IW-1:0] idle_cnt;
  logic [2:0]    age;

  always_comb begin
    ce_ok  = (age + 3'd1) >= {1'b0, ce_acc};
    ce_rel = idle && !req_pending && !ce_n && (idle_cnt == IW'(HOLD - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n     <= 1'b1;
      age      <= '0;
      idle_cnt <= '0;
    end else begin
      if (start && ce_n) begin
        ce_n <= 1'b0;
        age  <= '0;
      end else if (!ce_n && age != AGE_MAX) begin
        age <= age + 3'd1;
      end
      if (!idle || req_pending || ce_n) idle_cnt <= '0;
      else if (ce_rel) begin
        ce_n     <= 1'b1;
        idle_cnt <= '0;
      end else idle_cnt <= idle_cnt + IW'(1);
    end
  end

  AST_CE_RISE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |-> $past(idle && !req_pending)); // R8
  AST_CE_FALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> $past(start)); // R7

endmodule

// File: rtl/nand_tg_busy.sv
module nand_tg_busy
  import nand_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [BUSY_W-1:0] dly,
  input  logic              rb,
  output logic              rb_valid
);

  logic [BUSY_W-1:0] bcnt;
  logic              waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt     <= '0;
      waiting  <= 1'b1;
      rb_valid <= 1'b0;
    end else if (arm) begin
      bcnt     <= dly;
      waiting  <= 1'b1;
      rb_valid <= 1'b0;
    end else if (bcnt != '0) begin
      bcnt <= bcnt - BUSY_W'(1);
    end else if (waiting && rb) begin
      waiting  <= 1'b0;
      rb_valid <= 1'b1;
    end
  end

  AST_NO_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != '0) |-> !rb_valid); // R9
  AST_READY_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_valid) |-> $past(rb)); // R10
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !rb_valid); // R9

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nand_tg_pkg::*;
#(
  parameter int CE_HOLD = 4,
  parameter int DQ_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     timing_word,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [DQ_W-1:0] req_byte,
  input  logic            req_busy,
  output logic            req_done,
  output logic [DQ_W-1:0] rd_byte,
  output logic            rb_valid,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic [DQ_W-1:0] nand_dq_out,
  output logic            nand_dq_oe,
  input  logic [DQ_W-1:0] nand_dq_in,
  input  logic            nand_rb
);

  localparam logic [DQ_W-1:0] RST_CODE = {DQ_W{1'b1}};

  nand_timing_t    tw;
  nand_state_e     st;
  nand_kind_e      kind_q;
  logic [DQ_W-1:0] byte_q;
  logic [DQ_W-1:0] rd_q;
  logic            busy_q, last_wr;
  logic            idle, start, is_read, do_turn;
  logic            ce_ok, ce_rel, last_clk, cap_clk, in_cycle;
  logic            unused_spare;

  always_comb begin
    tw           = nand_timing_t'(timing_word);
    unused_spare = ^tw.spare;
    idle         = (st == ST_IDLE);
    start        = req_valid && idle;
    is_read      = start ? (req_kind == 2'(K_RDAT)) : (kind_q == K_RDAT);
    do_turn      = (req_kind == 2'(K_RDAT)) && last_wr;
    in_cycle     = (st == ST_LOW) || (st == ST_HIGH);
  end

  nand_tg_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
    .do_turn(do_turn), .ce_ok(ce_ok),
    .wr_lo(tw.wr_lo), .wr_hi(tw.wr_hi), .rd_lo(tw.rd_lo), .rd_hi(tw.rd_hi),
    .turn(tw.turn), .st(st), .last_clk(last_clk), .cap_clk(cap_clk)
  );

  nand_tg_ce #(.HOLD(CE_HOLD)) i_ce (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
    .req_pending(req_valid), .ce_acc(tw.ce_acc),
    .ce_n(nand_ce_n), .ce_ok(ce_ok), .ce_rel(ce_rel)
  );

  nand_tg_busy i_busy (
    .clk(clk), .rst_n(rst_n), .arm(last_clk && busy_q),
    .dly(tw.busy_dly), .rb(nand_rb), .rb_valid(rb_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_CMD;
      byte_q  <= '0;
      busy_q  <= 1'b0;
      last_wr <= 1'b0;
      rd_q    <= '0;
    end else begin
      if (start) begin
        kind_q <= nand_kind_e'(req_kind);
        byte_q <= req_byte;
        busy_q <= req_busy || ((req_kind == 2'(K_CMD)) && (req_byte == RST_CODE));
      end
      if (ce_rel) last_wr <= 1'b0;
      else if (last_clk) last_wr <= (kind_q != K_RDAT);
      if (cap_clk && kind_q == K_RDAT) rd_q <= nand_dq_in;
    end
  end

  always_comb begin
    nand_we_n   = !((st == ST_LOW) && (kind_q != K_RDAT));
    nand_re_n   = !((st == ST_LOW) && (kind_q == K_RDAT));
    nand_cle    = in_cycle && (kind_q == K_CMD);
    nand_ale    = in_cycle && (kind_q == K_ADDR);
    nand_dq_oe  = in_cycle && (kind_q != K_RDAT);
    nand_dq_out = byte_q;
    req_done    = last_clk;
    rd_byte     = rd_q;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R12
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R12
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R3
  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R5
  AST_READ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_re_n) |-> !$past(nand_dq_oe)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R7
  AST_DATA_HELD_AT_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (nand_dq_oe && $stable(nand_dq_out))); // R3

endmodule

// File: tb/test_nand_cycle_gen.sv
module test_nand_cycle_gen;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;

  localparam logic [31:0] TW_A = 32'h012A2312;
  localparam logic [31:0] TW_B = 32'h03000000;
  localparam logic [31:0] TW_C = 32'h021D4134;

  // {wait_release, busy, kind, byte, timing word}
  localparam int NV = 13;
  localparam logic [43:0] VECS [NV] = '{
    {1'b1, 1'b0, 2'd0, 8'h00, TW_A},
    {1'b0, 1'b0, 2'd1, 8'h12, TW_A},
    {1'b0, 1'b0, 2'd2, 8'hA5, TW_A},
    {1'b0, 1'b0, 2'd3, 8'h3C, TW_A},
    {1'b0, 1'b0, 2'd3, 8'hC3, TW_A},
    {1'b1, 1'b0, 2'd3, 8'h5A, TW_A},
    {1'b1, 1'b0, 2'd3, 8'h96, TW_B},
    {1'b0, 1'b0, 2'd0, 8'h80, TW_B},
    {1'b0, 1'b0, 2'd3, 8'h69, TW_B},
    {1'b1, 1'b0, 2'd2, 8'h0F, TW_C},
    {1'b0, 1'b0, 2'd3, 8'hF0, TW_C},
    {1'b0, 1'b0, 2'd1, 8'h77, TW_C},
    {1'b1, 1'b0, 2'd3, 8'h81, TW_C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_word = TW_A;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [7:0]  req_byte = 8'h00;
  logic        req_busy = 1'b0;
  logic        req_done, rb_valid;
  logic [7:0]  rd_byte, nand_dq_out, nand_dq_in;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic        nand_rb = 1'b1;
  logic [7:0]  model_byte = 8'h00;

  int  n_chk = 0;
  int  n_bad = 0;
  logic prev_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // device model: byte is driven only while the read strobe is low
  assign nand_dq_in = nand_re_n ? 8'h00 : model_byte;

  nand_cycle_gen #(.CE_HOLD(HOLD), .DQ_W(8)) i_nand_cycle_gen (
    .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
    .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
    .req_busy(req_busy), .req_done(req_done), .rd_byte(rd_byte),
    .rb_valid(rb_valid), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] x);
    return (x == 4'd0) ? 1 : int'(x);
  endfunction

  task automatic run_req(input logic rel, input logic bsy, input logic [1:0] kd,
                         input logic [7:0] dat, input logic [31:0] tw);
    int n, wl, rl, exp_n, exp_wl, exp_rl, t, le, guard;
    logic fresh, turn, bad, bad2;
    @(negedge clk);
    if (rel) begin
      guard = 0;
      while (nand_ce_n !== 1'b1 && guard < 50) begin
        @(negedge clk);
        guard++;
      end
    end
    if (nand_ce_n) prev_wr = 1'b0;
    fresh = nand_ce_n;
    turn  = !fresh && prev_wr && (kd == 2'd3);
    timing_word = tw; req_kind = kd; req_byte = dat; req_busy = bsy;
    model_byte = dat; req_valid = 1'b1;
    n = 0; wl = 0; rl = 0; bad = 1'b0; bad2 = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (!nand_we_n) begin
        wl++;
        if (nand_cle !== (kd == 2'd0) || nand_ale !== (kd == 2'd1) ||
            nand_dq_oe !== 1'b1 || nand_dq_out !== dat) bad = 1'b1;
      end
      if (!nand_re_n) rl++;
      if ((!nand_we_n && !nand_re_n) || ((!nand_we_n || !nand_re_n) && nand_ce_n))
        bad2 = 1'b1;
    end while (!req_done && n < 200);
    req_valid = 1'b0;
    if (kd != 2'd3) begin
      exp_wl = eff(tw[3:0]);
      exp_rl = 0;
      exp_n  = exp_wl + eff(tw[7:4]);
      chk("R2 write cycle clocks", n, exp_n);
      chk("R2 write strobe low clocks", wl, exp_wl);
      chk("R3 latch enables and driven byte", int'(bad), 0);
    end else begin
      t  = turn ? eff({1'b0, tw[18:16]}) : 0;
      le = t + eff(tw[11:8]);
      if (fresh && int'(tw[25:24]) > le) le = int'(tw[25:24]);
      exp_rl = le - t;
      exp_n  = le + eff(tw[15:12]);
      chk(turn ? "R5 read clocks with turnaround" :
          (fresh ? "R6 read clocks with access delay" : "R4 read clocks"), n, exp_n);
      chk(fresh ? "R6 read strobe low clocks" : "R4 read strobe low clocks", rl, exp_rl);
      chk("R4 captured byte", int'(rd_byte), int'(dat));
    end
    chk("R12 strobe exclusion", int'(bad2), 0);
    prev_wr = (kd != 2'd3);
    @(negedge clk);
    chk("R7 done is one clock", int'(req_done), 0);
  endtask

  // counts negedges from the current one until sig reaches level
  task automatic count_until_ce(output int k);
    k = 1;
    while (nand_ce_n !== 1'b1 && k < 60) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic count_until_rbv(output int k);
    k = 1;
    while (rb_valid !== 1'b1 && k < 60) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    logic [43:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n in reset", int'(nand_ce_n), 1);
    chk("R1 strobes in reset", int'({nand_we_n, nand_re_n}), 3);
    chk("R1 latch and drive in reset", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
    chk("R1 done and ready in reset", int'({req_done, rb_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run_req(v[43], v[42], v[41:40], v[39:32], v[31:0]);
    end

    // R8: hold across back-to-back, release after the idle timeout
    run_req(1'b0, 1'b0, 2'd1, 8'h44, TW_A);
    chk("R8 ce held between requests", int'(nand_ce_n), 0);
    count_until_ce(k);
    chk("R8 ce release delay", k, HOLD + 1);

    // R9: busy delay with the pin ready
    run_req(1'b0, 1'b1, 2'd0, 8'h30, TW_A);
    chk("R9 ready cleared after busy cycle", int'(rb_valid), 0);
    count_until_rbv(k);
    chk("R9 ready after busy delay", k, 5 + 2);

    // R11: non-busy command leaves ready alone; 0xFF acts as busy
    run_req(1'b0, 1'b0, 2'd0, 8'h70, TW_A);
    chk("R11 plain command keeps ready", int'(rb_valid), 1);
    run_req(1'b0, 1'b0, 2'd0, 8'hFF, TW_A);
    chk("R11 reset command clears ready", int'(rb_valid), 0);
    count_until_rbv(k);
    chk("R11 reset command busy delay", k, 5 + 2);

    // R10: pin held low past the delay
    nand_rb = 1'b0;
    run_req(1'b0, 1'b1, 2'd0, 8'h10, TW_A);
    repeat (10) @(negedge clk);
    chk("R10 ready held low by pin", int'(rb_valid), 0);
    nand_rb = 1'b1;
    @(negedge clk);
    chk("R10 ready rises with pin", int'(rb_valid), 1);

    // R9 with zero delay: rises one clock after the cycle ends
    run_req(1'b0, 1'b1, 2'd0, 8'h60, TW_B);
    count_until_rbv(k);
    chk("R9 zero busy delay", k, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule